// File: doc/BRIEF.md
# Configurable GPIO Mode Multiplexer

This block drives eight general-purpose pins that belong to a four-port device, two pins per port. For each pin it computes the output value and output enable that go to the pad, brings the pad's input value into the clock domain through a synchronizer, and routes selected pins into the core as global control inputs. Pad cells and the alarm logic that produces each port's alarm statuses are outside the block.

Without a global selection, a pin can be an input, drive one of its port's alarm statuses (chosen by a 4-bit selector), or drive a constant 0 or 1. The second pin of each port can be taken over by a global function instead. Pin index 1 sends the core's 8 kHz reference out. Pin indices 3, 5 and 7 bring in, in that order, an 8 kHz reference, an error-insert request and a performance-monitor update. A global selection overrides the pin's mode. A port marked disabled forces its alarm-driving pins low. A global input whose pin is not selected reaches the core as 0.

Pad outputs are registered, so a configuration change shows on the pins one clock later. Pin inputs reach readback and the global core inputs after two synchronizer flops.

Top module: `gpio_mode_mux`

## Requirements
- R1: While reset is held, and at the first clock after it, every pin has output enable 0 and output value 0. Every global core input is 0.
- R2: A pin with mode 00 and no global selection has output enable 0 and output value 0.
- R3: A pin with mode 10 drives 0 and a pin with mode 11 drives 1, each with output enable 1, one clock after the mode is applied.
- R4: A pin with mode 01 drives `port_alarms[port*16 + sel]` with output enable 1. Here port is pin index divided by two and sel is the pin's 4-bit field at `cfg_alarm_sel[4*pin +: 4]`. The pin's mode sits at `cfg_mode[2*pin +: 2]`.
- R5: When `port_disabled[port]` is 1, that port's pins in mode 01 drive 0 with output enable 1. Modes 10 and 11 on those pins behave as in R3.
- R6: With `cfg_glb_en[0]` set, pin index 1 drives the value `ref8k_core` had one clock earlier, with output enable 1, whatever its mode.
- R7: With `cfg_glb_en[g]` set for g in 1..3, pin index 2g+1 has output enable 0 whatever its mode. Its synchronized input is delivered as `core_ref8k_in` (g=1), `core_err_ins` (g=2) or `core_pm_update` (g=3).
- R8: Each global core input is 0 while its enable bit is clear, whatever level its pin carries.
- R9: `pin_rd` equals `pin_in` as it was two clocks earlier, in every mode.
- R10: Even pin indices (0, 2, 4, 6) are never global-capable, and `cfg_glb_en` has no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 16 | 2-bit mode per pin |
| cfg_alarm_sel | input | 32 | 4-bit alarm selector per pin |
| cfg_glb_en | input | 4 | Global enables: ref out, ref in, error insert, PM update |
| port_disabled | input | 4 | One bit per port; 1 = port disabled |
| port_alarms | input | 64 | 16 alarm statuses per port |
| ref8k_core | input | 1 | Core 8 kHz reference to drive out |
| pin_in | input | 8 | Pad input values |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_rd | output | 8 | Synchronized pad readback |
| core_ref8k_in | output | 1 | 8 kHz reference into the core |
| core_err_ins | output | 1 | Error-insert request into the core |
| core_pm_update | output | 1 | Performance-monitor update into the core |

## Verification
The bench builds the block with its default parameters: four ports, sixteen alarm statuses per port and two synchronizer stages. With these values the selector extremes 0 and 15 can be reached on both the first and the last port. All four global functions sit on their fixed pins. The two-clock input latency can be observed edge by edge. Alarm routing, port disabling and global overrides are each driven against mixed mode settings, so that a wrong pin-to-port or enable-to-pin mapping shows on the ports.

// File: rtl/gpio_mux_pkg.sv
// Shared encodings for the GPIO mode multiplexer.
// Assumes the global functions sit on the second pin of ports 0..3.
package gpio_mux_pkg;
    typedef enum logic [1:0] {
        PM_INPUT  = 2'b00,
        PM_ALARM  = 2'b01,
        PM_DRIVE0 = 2'b10,
        PM_DRIVE1 = 2'b11
    } pin_mode_e;

    localparam int GLB_COUNT   = 4;
    localparam int GLB_REF_OUT = 0;
    localparam int GLB_REF_IN  = 1;
    localparam int GLB_ERR_IN  = 2;
    localparam int GLB_PMU_IN  = 3;
endpackage

// File: rtl/gpio_bit_sync.sv
// Multi-stage flop synchronizer for a vector of independent bits.
// Assumes each bit is asynchronous and that no bit-to-bit coherence is needed.
module gpio_bit_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage captures the raw pad value.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // Later stages settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pin_ctrl.sv
// Output value and enable for one pin, registered.
// Assumes glb_sel is only ever set for a global-capable pin.
module gpio_pin_ctrl
    import gpio_mux_pkg::*;
#(
    parameter  int NUM_ALARMS = 16,
    localparam int SEL_W      = $clog2(NUM_ALARMS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode,
    input  logic [SEL_W-1:0]      alarm_sel,
    input  logic [NUM_ALARMS-1:0] alarms,
    input  logic                  port_dis,
    input  logic                  glb_sel,
    input  logic                  glb_drives,
    input  logic                  glb_val,
    output logic                  pad_out,
    output logic                  pad_oe
);
    pin_mode_e m;
    logic      nxt_out;
    logic      nxt_oe;

    assign m = pin_mode_e'(mode);

    // Pick the pad value: a global selection first, then the pin mode.
    always_comb begin
        nxt_out = 1'b0;
        nxt_oe  = 1'b0;
        if (glb_sel) begin
            nxt_out = glb_drives & glb_val;
            nxt_oe  = glb_drives;
        end else begin
            unique case (m)
                PM_INPUT:  begin nxt_out = 1'b0; nxt_oe = 1'b0; end
                PM_ALARM:  begin nxt_out = !port_dis && alarms[alarm_sel]; nxt_oe = 1'b1; end
                PM_DRIVE0: begin nxt_out = 1'b0; nxt_oe = 1'b1; end
                PM_DRIVE1: begin nxt_out = 1'b1; nxt_oe = 1'b1; end
                default:   begin nxt_out = 1'b0; nxt_oe = 1'b0; end
            endcase
        end
    end

    // Register the pad drive so the pad sees glitch-free levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_out <= 1'b0;
            pad_oe  <= 1'b0;
        end else begin
            pad_out <= nxt_out;
            pad_oe  <= nxt_oe;
        end
    end
endmodule

// File: rtl/gpio_glb_route.sv
// Maps the global enables onto pins and gates the global inputs to the core.
// Assumes global function g lives on pin index 2g+1 and that function 0 is the
// only one that drives out.
module gpio_glb_route
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic [GLB_COUNT-1:0] glb_en,
    input  logic [NUM_PINS-1:0]  pin_sync,
    output logic [NUM_PINS-1:0]  pin_glb_sel,
    output logic [NUM_PINS-1:0]  pin_glb_drives,
    output logic                 core_ref8k_in,
    output logic                 core_err_ins,
    output logic                 core_pm_update
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        if ((p % 2 == 1) && (p / 2 < GLB_COUNT)) begin : g_cap
            assign pin_glb_sel[p]    = glb_en[p/2];
            assign pin_glb_drives[p] = (p / 2 == GLB_REF_OUT);
        end else begin : g_plain
            assign pin_glb_sel[p]    = 1'b0;
            assign pin_glb_drives[p] = 1'b0;
        end
    end

    // Unselected global inputs reach the core as zero.
    assign core_ref8k_in  = glb_en[GLB_REF_IN] & pin_sync[2*GLB_REF_IN+1];
    assign core_err_ins   = glb_en[GLB_ERR_IN] & pin_sync[2*GLB_ERR_IN+1];
    assign core_pm_update = glb_en[GLB_PMU_IN] & pin_sync[2*GLB_PMU_IN+1];
endmodule

// File: rtl/gpio_mode_mux.sv
// Top level: per-pin drive control, input synchronizers and global routing.
// Assumes NUM_PORTS is at least 4 so that every global pin exists.
module gpio_mode_mux
    import gpio_mux_pkg::*;
#(
    parameter  int NUM_PORTS   = 4,
    parameter  int NUM_ALARMS  = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int PINS_PER_PORT = 2,
    localparam int NUM_PINS    = NUM_PORTS * PINS_PER_PORT,
    localparam int SEL_W       = $clog2(NUM_ALARMS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [2*NUM_PINS-1:0]           cfg_mode,
    input  logic [SEL_W*NUM_PINS-1:0]       cfg_alarm_sel,
    input  logic [GLB_COUNT-1:0]            cfg_glb_en,
    input  logic [NUM_PORTS-1:0]            port_disabled,
    input  logic [NUM_PORTS*NUM_ALARMS-1:0] port_alarms,
    input  logic                            ref8k_core,
    input  logic [NUM_PINS-1:0]             pin_in,
    output logic [NUM_PINS-1:0]             pin_out,
    output logic [NUM_PINS-1:0]             pin_oe,
    output logic [NUM_PINS-1:0]             pin_rd,
    output logic                            core_ref8k_in,
    output logic                            core_err_ins,
    output logic                            core_pm_update
);
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] glb_sel;
    logic [NUM_PINS-1:0] glb_drives;

    gpio_bit_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    assign pin_rd = pin_sync;

    gpio_glb_route #(.NUM_PINS(NUM_PINS)) u_route (
        .glb_en         (cfg_glb_en),
        .pin_sync       (pin_sync),
        .pin_glb_sel    (glb_sel),
        .pin_glb_drives (glb_drives),
        .core_ref8k_in  (core_ref8k_in),
        .core_err_ins   (core_err_ins),
        .core_pm_update (core_pm_update)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int PORT = p / PINS_PER_PORT;
        gpio_pin_ctrl #(.NUM_ALARMS(NUM_ALARMS)) u_pin (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode       (cfg_mode[2*p +: 2]),
            .alarm_sel  (cfg_alarm_sel[SEL_W*p +: SEL_W]),
            .alarms     (port_alarms[NUM_ALARMS*PORT +: NUM_ALARMS]),
            .port_dis   (port_disabled[PORT]),
            .glb_sel    (glb_sel[p]),
            .glb_drives (glb_drives[p]),
            .glb_val    (ref8k_core),
            .pad_out    (pin_out[p]),
            .pad_oe     (pin_oe[p])
        );
    end
endmodule

// File: rtl/gpio_mode_mux_chk.sv
// Assertion checker for gpio_mode_mux, attached by bind.
// Assumes the default pin-to-global mapping (function g on pin 2g+1).
module gpio_mode_mux_chk
    import gpio_mux_pkg::*;
#(
    parameter  int NUM_PORTS  = 4,
    parameter  int NUM_ALARMS = 16,
    localparam int NUM_PINS   = NUM_PORTS * 2,
    localparam int SEL_W      = $clog2(NUM_ALARMS)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [2*NUM_PINS-1:0]           cfg_mode,
    input logic [SEL_W*NUM_PINS-1:0]       cfg_alarm_sel,
    input logic [GLB_COUNT-1:0]            cfg_glb_en,
    input logic [NUM_PORTS-1:0]            port_disabled,
    input logic [NUM_PORTS*NUM_ALARMS-1:0] port_alarms,
    input logic                            ref8k_core,
    input logic [NUM_PINS-1:0]             pin_in,
    input logic [NUM_PINS-1:0]             pin_out,
    input logic [NUM_PINS-1:0]             pin_oe,
    input logic [NUM_PINS-1:0]             pin_rd,
    input logic                            core_ref8k_in,
    input logic                            core_err_ins,
    input logic                            core_pm_update
);
    logic [1:0] since_rst;

    // Count clocks since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    // R9: readback is the input two clocks late.
    a_r9_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst == 2'd2 |-> pin_rd == $past(pin_in, 2));

    // R8: gated global inputs stay low while not selected.
    a_r8_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_glb_en[GLB_REF_IN] && !cfg_glb_en[GLB_ERR_IN] && !cfg_glb_en[GLB_PMU_IN]
        |-> !core_ref8k_in && !core_err_ins && !core_pm_update);

    // R6: the reference output follows the core reference one clock late.
    a_r6_ref_out: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_glb_en[GLB_REF_OUT] |=> pin_oe[1] && pin_out[1] == $past(ref8k_core));

    for (genvar g = 1; g < GLB_COUNT; g++) begin : g_glb
        // R7: a pin taken as a global input never drives.
        a_r7_global_in_float: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_glb_en[g] |=> !pin_oe[2*g+1]);
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic glb_on;
        if (p % 2 == 1) begin : g_cap
            assign glb_on = cfg_glb_en[p/2];
        end else begin : g_plain
            assign glb_on = 1'b0;
        end
        // R3: constant modes drive their level one clock later.
        a_r3_const_drive: assert property (@(posedge clk) disable iff (!rst_n)
            !glb_on && cfg_mode[2*p+1] |=> pin_oe[p] && pin_out[p] == $past(cfg_mode[2*p]));
        // R5: a disabled port's alarm pins drive low.
        a_r5_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
            !glb_on && cfg_mode[2*p +: 2] == 2'b01 && port_disabled[p/2] |=> pin_oe[p] && !pin_out[p]);
        // R2: input mode leaves the pad undriven.
        a_r2_input_float: assert property (@(posedge clk) disable iff (!rst_n)
            !glb_on && cfg_mode[2*p +: 2] == 2'b00 |=> !pin_oe[p] && !pin_out[p]);
    end
endmodule

bind gpio_mode_mux gpio_mode_mux_chk #(.NUM_PORTS(NUM_PORTS), .NUM_ALARMS(NUM_ALARMS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_mode       (cfg_mode),
    .cfg_alarm_sel  (cfg_alarm_sel),
    .cfg_glb_en     (cfg_glb_en),
    .port_disabled  (port_disabled),
    .port_alarms    (port_alarms),
    .ref8k_core     (ref8k_core),
    .pin_in         (pin_in),
    .pin_out        (pin_out),
    .pin_oe         (pin_oe),
    .pin_rd         (pin_rd),
    .core_ref8k_in  (core_ref8k_in),
    .core_err_ins   (core_err_ins),
    .core_pm_update (core_pm_update)
);

// File: tb/gpio_mode_mux_test.sv
// Directed bench for gpio_mode_mux; one task per scenario.
module gpio_mode_mux_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_mode = '0;
    logic [31:0] cfg_alarm_sel = '0;
    logic [3:0]  cfg_glb_en = '0;
    logic [3:0]  port_disabled = '0;
    logic [63:0] port_alarms = '0;
    logic        ref8k_core = 1'b0;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe, pin_rd;
    logic        core_ref8k_in, core_err_ins, core_pm_update;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    gpio_mode_mux uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_alarm_sel(cfg_alarm_sel),
        .cfg_glb_en(cfg_glb_en), .port_disabled(port_disabled), .port_alarms(port_alarms),
        .ref8k_core(ref8k_core), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_rd(pin_rd), .core_ref8k_in(core_ref8k_in), .core_err_ins(core_err_ins),
        .core_pm_update(core_pm_update)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [15:0] all_mode(input logic [1:0] m);
        return {8{m}};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        cfg_mode = all_mode(2'b11);
        cfg_glb_en = 4'hF;
        pin_in = 8'hFF;
        repeat (3) step();
        check("R1 oe in reset", {24'd0, pin_oe}, 32'd0);
        check("R1 out in reset", {24'd0, pin_out}, 32'd0);
        check("R1 globals in reset", {29'd0, core_ref8k_in, core_err_ins, core_pm_update}, 32'd0);
        cfg_mode = '0;
        cfg_glb_en = '0;
        pin_in = '0;
        rst_n = 1'b1;
        step();
        check("R1 oe after release", {24'd0, pin_oe}, 32'd0);
    endtask

    task automatic t_input_readback();
        cfg_mode = all_mode(2'b00);
        pin_in = 8'hA5;
        step();
        check("R2 input oe", {24'd0, pin_oe}, 32'd0);
        check("R2 input out", {24'd0, pin_out}, 32'd0);
        check("R9 rd after one clock", {24'd0, pin_rd}, 32'd0);
        step();
        check("R9 rd after two clocks", {24'd0, pin_rd}, 32'h0000_00A5);
        cfg_mode = all_mode(2'b11);
        pin_in = 8'h3C;
        step();
        step();
        check("R9 rd in drive mode", {24'd0, pin_rd}, 32'h0000_003C);
    endtask

    task automatic t_const();
        cfg_mode = 16'hDDDD; // even pins mode 01? no: 11,01 pattern replaced below
        for (int p = 0; p < 8; p++) cfg_mode[2*p +: 2] = (p % 2 == 0) ? 2'b10 : 2'b11;
        step();
        check("R3 const out", {24'd0, pin_out}, 32'h0000_00AA);
        check("R3 const oe", {24'd0, pin_oe}, 32'h0000_00FF);
        for (int p = 0; p < 8; p++) cfg_mode[2*p +: 2] = (p % 2 == 0) ? 2'b11 : 2'b10;
        step();
        check("R3 const out swapped", {24'd0, pin_out}, 32'h0000_0055);
    endtask

    task automatic t_alarm(input logic [3:0] dis);
        logic [7:0] exp;
        port_alarms = 64'hF0F0_1234_8001_A5C3;
        port_disabled = dis;
        cfg_mode = all_mode(2'b01);
        for (int p = 0; p < 8; p++) cfg_alarm_sel[4*p +: 4] = 4'((p * 5 + 3) % 16);
        cfg_alarm_sel[3:0] = 4'd0;
        cfg_alarm_sel[31:28] = 4'd15;
        for (int p = 0; p < 8; p++)
            exp[p] = !dis[p/2] && port_alarms[(p/2)*16 + int'(cfg_alarm_sel[4*p +: 4])];
        step();
        check(dis == 0 ? "R4 alarm out" : "R5 disabled alarm out", {24'd0, pin_out}, {24'd0, exp});
        check(dis == 0 ? "R4 alarm oe" : "R5 disabled alarm oe", {24'd0, pin_oe}, 32'h0000_00FF);
        port_alarms = ~port_alarms;
        for (int p = 0; p < 8; p++)
            exp[p] = !dis[p/2] && port_alarms[(p/2)*16 + int'(cfg_alarm_sel[4*p +: 4])];
        step();
        check(dis == 0 ? "R4 alarm inverted" : "R5 disabled inverted", {24'd0, pin_out}, {24'd0, exp});
        if (dis != 0) begin
            cfg_mode = all_mode(2'b11);
            step();
            check("R5 disabled port const", {24'd0, pin_out}, 32'h0000_00FF);
        end
        port_disabled = '0;
    endtask

    task automatic t_ref_out();
        cfg_mode = all_mode(2'b00);
        cfg_glb_en = 4'b0001;
        ref8k_core = 1'b1;
        step();
        check("R6 ref out high", {30'd0, pin_oe[1], pin_out[1]}, 32'd3);
        ref8k_core = 1'b0;
        step();
        check("R6 ref out low", {30'd0, pin_oe[1], pin_out[1]}, 32'd2);
        cfg_mode = all_mode(2'b11);
        cfg_glb_en = 4'hF;
        ref8k_core = 1'b1;
        step();
        check("R10 even pins keep mode", {24'd0, pin_oe & 8'h55, pin_out & 8'h55} >> 8, 32'h55);
        check("R10 even pins out", {24'd0, pin_out & 8'h55}, 32'h55);
        check("R7 global inputs undriven", {24'd0, pin_oe & 8'hAA}, 32'h02);
        check("R6 ref out overrides mode", {31'd0, pin_out[1]}, 32'd1);
        ref8k_core = 1'b0;
    endtask

    task automatic t_glb_in();
        cfg_mode = all_mode(2'b00);
        cfg_glb_en = 4'b1110;
        pin_in = 8'b1010_1000;
        step();
        step();
        check("R7 globals delivered", {29'd0, core_ref8k_in, core_err_ins, core_pm_update}, 32'd7);
        pin_in = 8'b0010_0000;
        step();
        step();
        check("R7 only error insert", {29'd0, core_ref8k_in, core_err_ins, core_pm_update}, 32'd2);
        pin_in = 8'hFF;
        cfg_glb_en = 4'b0001;
        step();
        step();
        check("R8 unselected forced low", {29'd0, core_ref8k_in, core_err_ins, core_pm_update}, 32'd0);
        pin_in = 8'h55;
        cfg_glb_en = 4'hF;
        step();
        step();
        check("R10 even pins not sources", {29'd0, core_ref8k_in, core_err_ins, core_pm_update}, 32'd0);
        cfg_glb_en = '0;
    endtask

    initial begin
        step();
        t_reset();
        t_input_readback();
        t_const();
        t_alarm(4'b0000);
        t_alarm(4'b0101);
        t_ref_out();
        t_glb_in();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule